// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers event requests from a parameterised set of sources and decides when a processor core must branch to an interrupt vector. Every source owns three bits: a pending flag, an arming enable and a level select. The core reads and writes four small registers through a simple select/data port. It receives a one-cycle vector request with the vector address, and it pulses a return strobe when a service routine ends.

Two operating styles exist. In the flat style, a single global enable gates everything. A second enable gates the non-core sources only, every request goes to one vector, and the level bits do nothing. In the two-level style, the same two control bits become separate enables for the high and the low level, each level has its own vector, and a high request may interrupt low service in progress. When a request is taken, the controller clears the enable of the serviced level by itself. On the return strobe, it sets that enable again and resumes any interrupted low service.

Event inputs are asynchronous. Each one passes through a two-flop synchroniser, and its rising edge sets the matching flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all four registers read zero, `vec_req` is low and `vec_addr` is zero.
- R2: The register selects are: 0 control, 1 flags, 2 enables, 3 levels (1 = high). Bit n of registers 1 to 3 belongs to source n. In the control register, bit 7 is the global/high enable, bit 6 is the peripheral/low enable and bit 0 selects the two-level style. A write is visible on `rd_data` after the next clock edge.
- R3: If a rising edge on `evt_in[n]` is first sampled at clock edge k, flag n reads 1 after edge k+2. If the source can be taken, `vec_req` is high after edge k+3.
- R4: A flag is set by its event whatever the enables hold. Only a write to the flag register clears it. If an event edge and a write clearing that flag land in the same cycle, the flag ends up set.
- R5: In the flat style (control bit 0 = 0), a source is taken when control bit 7 is set, its flag and enable are set, and either its index is below NCORE or control bit 6 is set. The vector is 0x0008 and level bits have no effect.
- R6: In the two-level style, an armed high source is taken with control bit 7 and goes to vector 0x0008. An armed low source also needs control bit 6 and goes to vector 0x0018. When both levels are pending, high wins.
- R7: When a request is taken, control bit 7 clears (flat or high) or control bit 6 clears (low) at the same edge that raises `vec_req`.
- R8: A `reti` pulse sets the enable bit of the level being left. With no service active, it changes nothing.
- R9: A high request pre-empts low service. No low request is taken while high service is active. After the nested high level returns, the next `reti` closes the low level and sets control bit 6.
- R10: A flag still set and armed after a return causes the request to be taken again.
- R11: No request is taken in a cycle where `reti` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NSRC | Asynchronous per-source event lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | NSRC | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | NSRC | Read data (combinational) |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| vec_req | output | 1 | One-cycle vector request |
| vec_addr | output | VAW | Vector address of the last request taken |

## Verification
The bench drives an event edge into the exact cycle where software writes zero to the flags. A design that let the write win would lose an interrupt. It builds a low-service, high-pre-emption, double-return sequence. If the design kept only one level of service state, it would restore the wrong enable or leave bit 6 cleared for good. It checks that a peripheral source stays silent in the flat style while bit 6 is low, that a return with a live flag re-enters only after the strobe cycle, and that the event-to-request latency matches exactly. A random phase then compares every cycle against a bench-side model.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int SEL_W        = 2;
    localparam int CTL_HI_BIT   = 7;
    localparam int CTL_LO_BIT   = 6;
    localparam int CTL_MODE_BIT = 0;

    typedef enum logic [SEL_W-1:0] {
        REG_CTL  = 2'd0,
        REG_FLAG = 2'd1,
        REG_EN   = 2'd2,
        REG_LVL  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SVC_NONE  = 2'd0,
        SVC_LO    = 2'd1,
        SVC_HI    = 2'd2,
        SVC_HI_LO = 2'd3
    } svc_e;

    // hardware-driven updates of the control register
    typedef struct packed {
        logic take_hi;
        logic take_lo;
        logic ret_hi;
        logic ret_lo;
    } ctl_upd_t;

    function automatic logic hi_active(svc_e s);
        return (s == SVC_HI) || (s == SVC_HI_LO);
    endfunction

    function automatic svc_e svc_after_take_hi(svc_e s);
        return (s == SVC_LO) ? SVC_HI_LO : SVC_HI;
    endfunction

    function automatic svc_e svc_after_ret_hi(svc_e s);
        return (s == SVC_HI_LO) ? SVC_LO : SVC_NONE;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_in,
    output logic [NSRC-1:0] rise
);
    logic [NSRC-1:0] meta_q;
    logic [NSRC-1:0] sync_q;
    logic [NSRC-1:0] prev_q;

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[gi] <= 1'b0;
                sync_q[gi] <= 1'b0;
                prev_q[gi] <= 1'b0;
            end else begin
                meta_q[gi] <= evt_in[gi];
                sync_q[gi] <= meta_q[gi];
                prev_q[gi] <= sync_q[gi];
            end
        end
        assign rise[gi] = sync_q[gi] & ~prev_q[gi];
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NSRC-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [NSRC-1:0]  rd_data,
    input  logic [NSRC-1:0]  rise,
    input  ctl_upd_t         upd,
    output logic [NSRC-1:0]  ctl,
    output logic [NSRC-1:0]  flag,
    output logic [NSRC-1:0]  en,
    output logic [NSRC-1:0]  lvl
);
    logic [NSRC-1:0] ctl_nx, flag_nx, en_nx, lvl_nx;
    logic            wr_ctl, wr_flag, wr_en_r, wr_lvl;

    assign wr_ctl  = wr_en && (reg_sel_e'(wr_sel) == REG_CTL);
    assign wr_flag = wr_en && (reg_sel_e'(wr_sel) == REG_FLAG);
    assign wr_en_r = wr_en && (reg_sel_e'(wr_sel) == REG_EN);
    assign wr_lvl  = wr_en && (reg_sel_e'(wr_sel) == REG_LVL);

    always_comb begin
        ctl_nx = wr_ctl ? wr_data : ctl;
        // hardware updates win over a same-cycle software write
        if (upd.take_hi) ctl_nx[CTL_HI_BIT] = 1'b0;
        if (upd.take_lo) ctl_nx[CTL_LO_BIT] = 1'b0;
        if (upd.ret_hi)  ctl_nx[CTL_HI_BIT] = 1'b1;
        if (upd.ret_lo)  ctl_nx[CTL_LO_BIT] = 1'b1;
        flag_nx = (wr_flag ? wr_data : flag) | rise;
        en_nx   = wr_en_r ? wr_data : en;
        lvl_nx  = wr_lvl  ? wr_data : lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            flag <= '0;
            en   <= '0;
            lvl  <= '0;
        end else begin
            ctl  <= ctl_nx;
            flag <= flag_nx;
            en   <= en_nx;
            lvl  <= lvl_nx;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            REG_CTL:  rd_data = ctl;
            REG_FLAG: rd_data = flag;
            REG_EN:   rd_data = en;
            default:  rd_data = lvl;
        endcase
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((flag & $past(rise)) == $past(rise)));

    p_lo_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        upd.take_lo |=> !ctl[CTL_LO_BIT]);

    p_lo_restored_r8: assert property (@(posedge clk) disable iff (rst)
        upd.ret_lo |=> ctl[CTL_LO_BIT]);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int NCORE = 2,
    parameter int VAW   = 16,
    parameter logic [VAW-1:0] HI_VEC = 16'h0008,
    parameter logic [VAW-1:0] LO_VEC = 16'h0018
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode,
    input  logic            hie,
    input  logic            lie,
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] lvl,
    input  logic            reti,
    output ctl_upd_t        upd,
    output logic            vec_req,
    output logic [VAW-1:0]  vec_addr
);
    localparam logic [NSRC-1:0] CORE_MASK = NSRC'((64'd1 << NCORE) - 64'd1);
    localparam logic [NSRC-1:0] ALL_MASK  = '1;

    svc_e            svc_q, svc_nx;
    logic [NSRC-1:0] armed;
    logic            flat_pend, hi_pend, lo_pend;
    logic            take_hi, take_lo, ret_hi, ret_lo;

    assign armed     = flag & en;
    assign flat_pend = |(armed & (lie ? ALL_MASK : CORE_MASK));
    assign hi_pend   = mode ? |(armed & lvl) : flat_pend;
    assign lo_pend   = mode && |(armed & ~lvl);

    assign take_hi = !reti && hie && hi_pend && !hi_active(svc_q);
    assign take_lo = !reti && mode && hie && lie && lo_pend
                     && (svc_q == SVC_NONE) && !take_hi;
    assign ret_hi  = reti && hi_active(svc_q);
    assign ret_lo  = reti && (svc_q == SVC_LO);

    assign upd = '{take_hi: take_hi, take_lo: take_lo,
                   ret_hi: ret_hi, ret_lo: ret_lo};

    always_comb begin
        svc_nx = svc_q;
        if (take_hi)      svc_nx = svc_after_take_hi(svc_q);
        else if (take_lo) svc_nx = SVC_LO;
        else if (ret_hi)  svc_nx = svc_after_ret_hi(svc_q);
        else if (ret_lo)  svc_nx = SVC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q    <= SVC_NONE;
            vec_req  <= 1'b0;
            vec_addr <= '0;
        end else begin
            svc_q   <= svc_nx;
            vec_req <= take_hi | take_lo;
            if (take_hi)      vec_addr <= HI_VEC;
            else if (take_lo) vec_addr <= LO_VEC;
        end
    end

    p_reti_no_take_r11: assert property (@(posedge clk) disable iff (rst)
        reti |=> !vec_req);

    p_lo_only_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (vec_req && vec_addr == LO_VEC) |-> ($past(svc_q) == SVC_NONE));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int NCORE = 2,
    parameter int VAW   = 16,
    parameter logic [VAW-1:0] HI_VEC = 16'h0008,
    parameter logic [VAW-1:0] LO_VEC = 16'h0018
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  evt_in,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NSRC-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [NSRC-1:0]  rd_data,
    input  logic             reti,
    output logic             vec_req,
    output logic [VAW-1:0]   vec_addr
);
    logic [NSRC-1:0] rise, ctl, flag, en, lvl;
    ctl_upd_t        upd;

    irq_edge_sync #(.NSRC(NSRC)) u_sync (
        .clk(clk), .rst(rst), .evt_in(evt_in), .rise(rise)
    );

    irq_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .rise(rise), .upd(upd), .ctl(ctl), .flag(flag), .en(en), .lvl(lvl)
    );

    irq_arbiter #(
        .NSRC(NSRC), .NCORE(NCORE), .VAW(VAW),
        .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
    ) u_arb (
        .clk(clk), .rst(rst),
        .mode(ctl[CTL_MODE_BIT]), .hie(ctl[CTL_HI_BIT]), .lie(ctl[CTL_LO_BIT]),
        .flag(flag), .en(en), .lvl(lvl), .reti(reti),
        .upd(upd), .vec_req(vec_req), .vec_addr(vec_addr)
    );

    p_hi_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        (vec_req && vec_addr == HI_VEC) |-> !ctl[CTL_HI_BIT]);

    p_flat_vector_r5: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !$past(ctl[CTL_MODE_BIT])) |-> (vec_addr == HI_VEC));

    p_lo_needs_mode_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_req && vec_addr == LO_VEC) |-> $past(ctl[CTL_MODE_BIT]));

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    localparam int NSRC = 8;
    localparam int VAW  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] evt_in = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = '0;
    logic [NSRC-1:0] wr_data = '0;
    logic [1:0]      rd_sel = '0;
    logic [NSRC-1:0] rd_data;
    logic            reti = 1'b0;
    logic            vec_req;
    logic [VAW-1:0]  vec_addr;

    int    n_run = 0;
    int    n_fail = 0;
    string cur_tag = "R1";

    // bench-side model state
    logic [7:0] m_s1, m_s2, m_pv, m_flag, m_en, m_lvl, m_ctl;
    int         m_svc;
    logic       m_vreq;
    logic [15:0] m_vaddr;

    always #5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .evt_in(evt_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .reti(reti),
        .vec_req(vec_req), .vec_addr(vec_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(logic [1:0] sel);
        case (sel)
            2'd0: return m_ctl;
            2'd1: return m_flag;
            2'd2: return m_en;
            default: return m_lvl;
        endcase
    endfunction

    task automatic m_reset();
        m_s1 = 0; m_s2 = 0; m_pv = 0; m_flag = 0; m_en = 0; m_lvl = 0;
        m_ctl = 0; m_svc = 0; m_vreq = 0; m_vaddr = 0;
    endtask

    // one clock: predict from the requirements, advance, compare
    task automatic step();
        logic [7:0] rise, armed, n_ctl, n_flag;
        logic mode, hie, lie, flatp, hp, lp, hb, th, tl, rh, rl;
        int n_svc;
        rise  = m_s2 & ~m_pv;
        armed = m_flag & m_en;
        mode = m_ctl[0]; hie = m_ctl[7]; lie = m_ctl[6];
        flatp = |(armed & (lie ? 8'hFF : 8'h03));
        hp = mode ? |(armed & m_lvl) : flatp;
        lp = mode && |(armed & ~m_lvl);
        hb = (m_svc == 2) || (m_svc == 3);
        th = !reti && hie && hp && !hb;
        tl = !reti && mode && hie && lie && lp && (m_svc == 0) && !th;
        rh = reti && hb;
        rl = reti && (m_svc == 1);
        n_ctl  = (wr_en && wr_sel == 2'd0) ? wr_data : m_ctl;
        n_flag = ((wr_en && wr_sel == 2'd1) ? wr_data : m_flag) | rise;
        if (th) n_ctl[7] = 1'b0;
        if (tl) n_ctl[6] = 1'b0;
        if (rh) n_ctl[7] = 1'b1;
        if (rl) n_ctl[6] = 1'b1;
        n_svc = m_svc;
        if (th)      n_svc = (m_svc == 1) ? 3 : 2;
        else if (tl) n_svc = 1;
        else if (rh) n_svc = (m_svc == 3) ? 1 : 0;
        else if (rl) n_svc = 0;
        @(posedge clk);
        #1;
        if (wr_en && wr_sel == 2'd2) m_en = wr_data;
        if (wr_en && wr_sel == 2'd3) m_lvl = wr_data;
        m_ctl = n_ctl; m_flag = n_flag; m_svc = n_svc;
        m_vreq = th | tl;
        if (th) m_vaddr = 16'h0008;
        else if (tl) m_vaddr = 16'h0018;
        m_pv = m_s2; m_s2 = m_s1; m_s1 = evt_in;
        chk({cur_tag, " vec_req"}, vec_req, m_vreq);
        chk({cur_tag, " vec_addr"}, vec_addr, m_vaddr);
        chk({cur_tag, " rd_data"}, rd_data, m_read(rd_sel));
        wr_en = 1'b0;
        reti  = 1'b0;
    endtask

    task automatic wreg(logic [1:0] sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
    endtask

    task automatic do_reti();
        reti = 1'b1;
        step();
    endtask

    task automatic rd_chk(string tag, logic [1:0] sel, logic [7:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int s = 0; s < 4; s++) rd_chk("R1 reset register", 2'(s), 8'h00);
        chk("R1 reset vec_req", vec_req, 0);
        chk("R1 reset vec_addr", vec_addr, 0);
        rst = 1'b0;

        // R2 register access
        cur_tag = "R2";
        wreg(2'd3, 8'h5A); rd_chk("R2 level readback", 2'd3, 8'h5A);
        wreg(2'd2, 8'hA5); rd_chk("R2 enable readback", 2'd2, 8'hA5);
        wreg(2'd3, 8'h00); wreg(2'd2, 8'h00);

        // R3 latency in flat style
        cur_tag = "R3";
        wreg(2'd2, 8'h08);
        wreg(2'd0, 8'hC0);
        rd_sel = 2'd1;
        evt_in[3] = 1'b1;
        step(); chk("R3 flag after k", rd_data, 8'h00);
        step(); chk("R3 flag after k+1", rd_data, 8'h00);
        step(); chk("R3 flag after k+2", rd_data, 8'h08);
        chk("R3 no request yet", vec_req, 0);
        rd_sel = 2'd0;
        step(); chk("R3 request after k+3", vec_req, 1);
        chk("R3 vector", vec_addr, 16'h0008);
        chk("R7 flat enable cleared", rd_data, 8'h40);
        evt_in[3] = 1'b0;
        wreg(2'd1, 8'h00);
        cur_tag = "R8";
        do_reti(); chk("R8 flat enable restored", rd_data, 8'hC0);
        do_reti(); chk("R8 idle return no change", rd_data, 8'hC0);

        // R4 set wins over clearing write, independent of enables
        cur_tag = "R4";
        wreg(2'd0, 8'h00);
        wreg(2'd2, 8'h00);
        evt_in[5] = 1'b1;
        step(); step();
        rd_sel = 2'd1;
        wreg(2'd1, 8'h00);
        chk("R4 set beats clear", rd_data, 8'h20);
        evt_in[5] = 1'b0;
        step(); step(); step();
        chk("R4 flag holds", rd_data, 8'h20);
        wreg(2'd1, 8'h00);
        chk("R4 software clear", rd_data, 8'h00);

        // R5 flat style peripheral gating and level bits ignored
        cur_tag = "R5";
        wreg(2'd3, 8'hFF);
        wreg(2'd2, 8'h12);
        wreg(2'd0, 8'h80);
        wreg(2'd1, 8'h10);
        step(); step();
        chk("R5 peripheral gated by bit 6", vec_req, 0);
        wreg(2'd1, 8'h12);
        step();
        chk("R5 core source taken", vec_req, 1);
        chk("R5 single vector", vec_addr, 16'h0008);
        wreg(2'd1, 8'h00);
        rd_sel = 2'd0;
        do_reti();
        chk("R8 flat restore", rd_data, 8'h80);

        // R6 / R9 two-level nesting
        cur_tag = "R6";
        wreg(2'd3, 8'h04);
        wreg(2'd2, 8'h24);
        wreg(2'd0, 8'hC1);
        wreg(2'd1, 8'h20);
        step();
        chk("R6 low taken", vec_req, 1);
        chk("R6 low vector", vec_addr, 16'h0018);
        chk("R7 low enable cleared", rd_data, 8'h81);
        cur_tag = "R9";
        wreg(2'd1, 8'h24);
        step();
        chk("R9 high pre-empts low", vec_req, 1);
        chk("R9 high vector", vec_addr, 16'h0008);
        chk("R7 high enable cleared", rd_data, 8'h01);
        wreg(2'd1, 8'h00);
        do_reti(); chk("R9 nested return keeps low", rd_data, 8'h81);
        do_reti(); chk("R9 low return restores", rd_data, 8'hC1);
        wreg(2'd1, 8'h04);
        step(); chk("R9 high taken", vec_req, 1);
        wreg(2'd1, 8'h20);
        step(); step();
        chk("R9 low blocked under high", vec_req, 0);
        do_reti();
        chk("R9 no take during return", vec_req, 0);
        step();
        chk("R9 low after high done", vec_req, 1);
        chk("R9 low vector after high", vec_addr, 16'h0018);
        wreg(2'd1, 8'h00);
        do_reti();

        // R10 / R11 re-entry with live flag
        cur_tag = "R10";
        wreg(2'd1, 8'h04);
        step(); chk("R10 first entry", vec_req, 1);
        step();
        do_reti();
        chk("R11 no take in return cycle", vec_req, 0);
        chk("R8 high restored", rd_data, 8'hC1);
        step();
        chk("R10 re-entry", vec_req, 1);
        chk("R10 re-entry vector", vec_addr, 16'h0008);
        wreg(2'd1, 8'h00);
        do_reti();

        // random phase against the model
        cur_tag = "R5 R6 R9 R11 random";
        for (int i = 0; i < 4000; i++) begin
            evt_in = 8'($urandom);
            rd_sel = 2'($urandom);
            if (($urandom % 5) == 0) begin
                wr_en   = 1'b1;
                wr_sel  = 2'($urandom);
                wr_data = 8'($urandom);
                if (wr_sel == 2'd0 && ($urandom % 3) != 0) wr_data[7:6] = 2'b11;
            end
            reti = (($urandom % 4) == 0);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule